// File: doc/BRIEF.md
# Indexed Region Info Register with Auto-Advancing Index

This block presents a small table of configuration words through one bus register. The table holds the inclusive lower and upper bounds of a protected memory region. Software picks a table entry by writing an index into the low nibble of the register. Each read returns the selected entry and then moves the index on by one, so two reads in a row return the lower bound and then the upper bound.

The table is filled once after reset, when a load strobe brings in the region's base byte address and its inclusive end byte address. Both bounds are kept in 256-byte units in bits [31:4] of the read word. The upper entry is deliberately stored 0x1FFFF bytes (128 KiB minus one) below the true end. Software restores the true end by adding that amount back, and then computes the size as upper minus lower plus one. A status output shows when the bounds have been captured.

Top module: `region_info_reg`

## Requirements
- R1: After reset, `loaded` is low, the read index is 0 and `bus_rdata` is all zero.
- R2: While `loaded` is low, `bus_rdata` is all zero and a read does not move the index. A write still sets the index.
- R3: The first `ld_stb` pulse after reset captures `ld_base` and `ld_limit`, and `loaded` is high from the next clock edge onward.
- R4: Once `loaded` is high, further `ld_stb` pulses leave the table unchanged until the next reset.
- R5: A write sets the read index to `bus_wdata[3:0]`. Bits [31:4] of the write data are ignored.
- R6: Once loaded, `bus_rdata[3:0]` shows the current index and `bus_rdata[31:4]` shows that entry's field. A read without a write moves the index on by one at the clock edge.
- R7: The index is 4 bits wide and wraps from 15 to 0 on a read.
- R8: Entry 2 holds the lower bound in 256-byte units: bits [31:4] equal `ld_base` shifted right by 8.
- R9: Entry 3 holds (`ld_limit` − 0x1FFFF) shifted right by 8 in bits [31:4]. Software gets the true inclusive end as (field × 256) + 0x1FFFF, and the region size as end − lower + 1.
- R10: All entries other than 2 and 3 read zero in bits [31:4].
- R11: When a write and a read occur in the same cycle, the write sets the index and the index does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_stb | input | 1 | Strobe that delivers the region bounds |
| ld_base | input | 36 | Region lower byte address, inclusive |
| ld_limit | input | 36 | Region upper byte address, inclusive |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Write data; bits [3:0] are the new index |
| bus_rdata | output | 32 | Read word: {entry field, current index} |
| loaded | output | 1 | High once the bounds have been captured |

## Verification
An index that is off by one shows up at once in `bus_rdata[3:0]`, in the same cycle as the read. It also makes the second read of a pair return the wrong field. A wrong or missing upper-bound offset is caught when the bench rebuilds the region end and size from the two read words and compares them with the values it loaded. A capture flag that re-arms is caught by a later strobe with new bounds followed by a read-back of entries 2 and 3. A collision that lets a read advance the index shows up on the very next read, which returns the wrong index.

// File: rtl/region_info_pkg.sv
package region_info_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned SEL_W   = 4;
   localparam int unsigned FIELD_W = WORD_W - SEL_W;
   localparam int unsigned UNIT_SH = 8;
   typedef logic [FIELD_W-1:0] field_t;
   typedef logic [SEL_W-1:0]   sel_t;
endpackage

// File: rtl/region_bounds_cap.sv
module region_bounds_cap
   import region_info_pkg::*;
#(
   parameter int unsigned ADDR_W  = 36,
   parameter bit          SKEW_EN = 1'b1,
   parameter logic [31:0] SKEW    = 32'h0001_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_stb,
   input  logic [ADDR_W-1:0] ld_base,
   input  logic [ADDR_W-1:0] ld_limit,
   output field_t            lo_fld,
   output field_t            hi_fld,
   output logic              done
);
   logic [ADDR_W-1:0] hi_adj;

   generate
      if (SKEW_EN) begin : g_skew
         assign hi_adj = ld_limit - ADDR_W'(SKEW);
      end else begin : g_noskew
         assign hi_adj = ld_limit;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_fld <= '0;
         hi_fld <= '0;
         done   <= 1'b0;
      end else if (ld_stb && !done) begin
         lo_fld <= FIELD_W'(ld_base >> UNIT_SH);
         hi_fld <= FIELD_W'(hi_adj >> UNIT_SH);
         done   <= 1'b1;
      end
   end
endmodule

// File: rtl/region_sel_ctr.sv
module region_sel_ctr
   import region_info_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic rd,
   input  logic armed,
   input  sel_t wsel,
   output sel_t sel
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         sel <= '0;
      else if (wr)
         sel <= wsel;
      else if (rd && armed)
         sel <= sel + sel_t'(1);
   end
endmodule

// File: rtl/region_table.sv
module region_table
   import region_info_pkg::*;
#(
   parameter int unsigned LO_IDX = 2,
   parameter int unsigned HI_IDX = 3
) (
   input  field_t lo_fld,
   input  field_t hi_fld,
   input  sel_t   sel,
   output field_t fld
);
   localparam int unsigned DEPTH = 1 << SEL_W;
   field_t slot [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         if (i == LO_IDX) begin : g_lo
            assign slot[i] = lo_fld;
         end else if (i == HI_IDX) begin : g_hi
            assign slot[i] = hi_fld;
         end else begin : g_nil
            assign slot[i] = '0;
         end
      end
   endgenerate

   assign fld = slot[sel];
endmodule

// File: rtl/region_info_reg.sv
module region_info_reg
   import region_info_pkg::*;
#(
   parameter int unsigned ADDR_W  = 36,
   parameter int unsigned LO_IDX  = 2,
   parameter int unsigned HI_IDX  = 3,
   parameter bit          SKEW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_stb,
   input  logic [ADDR_W-1:0] ld_base,
   input  logic [ADDR_W-1:0] ld_limit,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              loaded
);
   localparam int unsigned DEPTH = 1 << SEL_W;

   generate
      if (ADDR_W > FIELD_W + UNIT_SH || ADDR_W <= UNIT_SH + 9) begin : g_bad_aw
         $error("region_info_reg: ADDR_W out of range");
      end
      if (LO_IDX >= DEPTH || HI_IDX >= DEPTH || LO_IDX == HI_IDX) begin : g_bad_idx
         $error("region_info_reg: entry indices invalid");
      end
   endgenerate

   field_t lo_fld, hi_fld, fld;
   sel_t   sel;

   region_bounds_cap #(.ADDR_W(ADDR_W), .SKEW_EN(SKEW_EN)) u_cap (
      .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb),
      .ld_base(ld_base), .ld_limit(ld_limit),
      .lo_fld(lo_fld), .hi_fld(hi_fld), .done(loaded)
   );

   region_sel_ctr u_sel (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd),
      .armed(loaded), .wsel(bus_wdata[SEL_W-1:0]), .sel(sel)
   );

   region_table #(.LO_IDX(LO_IDX), .HI_IDX(HI_IDX)) u_tab (
      .lo_fld(lo_fld), .hi_fld(hi_fld), .sel(sel), .fld(fld)
   );

   assign bus_rdata = loaded ? {fld, sel} : '0;
endmodule

// File: rtl/region_info_reg_chk.sv
module region_info_reg_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ld_stb,
   input logic        bus_wr,
   input logic        bus_rd,
   input logic [31:0] bus_wdata,
   input logic [31:0] bus_rdata,
   input logic        loaded
);
   // R2
   zero_until_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !loaded |-> bus_rdata == 32'h0);

   // R3
   load_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loaded) |-> $past(ld_stb));

   // R4
   loaded_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loaded |=> loaded);

   // R4
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loaded && !bus_wr && !bus_rd) |=> $stable(bus_rdata));

   // R5
   write_sets_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && loaded) |=> bus_rdata[3:0] == $past(bus_wdata[3:0]));

   // R6
   read_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && loaded) |=> bus_rdata[3:0] == 4'($past(bus_rdata[3:0]) + 4'd1));
endmodule

bind region_info_reg region_info_reg_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .loaded(loaded)
);

// File: tb/sim_region_info_reg.sv
module sim_region_info_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_stb = 1'b0;
   logic [35:0] ld_base = '0;
   logic [35:0] ld_limit = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        loaded;

   int checks = 0;
   int fails  = 0;

   localparam logic [35:0] BASE  = 36'h1_2340_0000;
   localparam logic [35:0] SIZE  = 36'h0_0060_0000;
   localparam logic [35:0] LIMIT = BASE + SIZE - 36'd1;
   localparam logic [35:0] SKEW  = 36'h1_FFFF;

   always #2 clk = ~clk;

   region_info_reg u0 (
      .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_base(ld_base), .ld_limit(ld_limit),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .loaded(loaded)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_sel(input logic [31:0] v);
      @(negedge clk);
      bus_wr = 1'b1; bus_wdata = v;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_word(output logic [31:0] v);
      @(negedge clk);
      bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic load(input logic [35:0] b, input logic [35:0] l);
      @(negedge clk);
      ld_stb = 1'b1; ld_base = b; ld_limit = l;
      @(negedge clk);
      ld_stb = 1'b0; ld_base = '0; ld_limit = '0;
   endtask

   task automatic t_reset;
      #1;
      check("R1 loaded", 64'(loaded), 64'd0);
      check("R1 rdata", 64'(bus_rdata), 64'd0);
   endtask

   task automatic t_preload;
      logic [31:0] w;
      wr_sel(32'h2);
      rd_word(w);
      check("R2 read zero before load", 64'(w), 64'd0);
      rd_word(w);
      check("R2 second read zero", 64'(w), 64'd0);
   endtask

   task automatic t_load;
      load(BASE, LIMIT);
      #1;
      check("R3 loaded high", 64'(loaded), 64'd1);
      check("R2 index not advanced before load", 64'(bus_rdata[3:0]), 64'd2);
   endtask

   task automatic t_bounds;
      logic [31:0] w2, w3;
      logic [35:0] lo, hi;
      wr_sel(32'h2);
      rd_word(w2);
      rd_word(w3);
      check("R8 lower entry", 64'(w2), 64'({28'(BASE >> 8), 4'd2}));
      check("R9 upper entry", 64'(w3), 64'({28'((LIMIT - SKEW) >> 8), 4'd3}));
      lo = 36'(w2[31:4]) << 8;
      hi = (36'(w3[31:4]) << 8) + SKEW;
      check("R9 rebuilt end", 64'(hi), 64'(LIMIT));
      check("R9 rebuilt size", 64'(hi - lo + 36'd1), 64'(SIZE));
      #1 check("R6 index advanced to 4", 64'(bus_rdata[3:0]), 64'd4);
   endtask

   task automatic t_unpop;
      logic [31:0] w;
      rd_word(w);
      check("R10 entry 4", 64'(w), 64'h4);
      wr_sel(32'h0);
      rd_word(w);
      check("R10 entry 0", 64'(w), 64'h0);
      rd_word(w);
      check("R10 entry 1", 64'(w), 64'h1);
   endtask

   task automatic t_wrap;
      logic [31:0] w;
      wr_sel(32'hF);
      rd_word(w);
      check("R7 entry 15", 64'(w), 64'hF);
      rd_word(w);
      check("R7 wrap to 0", 64'(w), 64'h0);
   endtask

   task automatic t_wdata_hi;
      logic [31:0] w;
      wr_sel(32'hFFFF_FFF5);
      #1 check("R5 index from low nibble", 64'(bus_rdata), 64'h5);
      rd_word(w);
      check("R5 read after write", 64'(w), 64'h5);
   endtask

   task automatic t_reload_ignored;
      logic [31:0] w;
      load(36'h0_0010_0000, 36'h0_001F_FFFF);
      check("R4 loaded stays", 64'(loaded), 64'd1);
      wr_sel(32'h2);
      rd_word(w);
      check("R4 lower unchanged", 64'(w), 64'({28'(BASE >> 8), 4'd2}));
      rd_word(w);
      check("R4 upper unchanged", 64'(w), 64'({28'((LIMIT - SKEW) >> 8), 4'd3}));
   endtask

   task automatic t_collide;
      logic [31:0] w;
      @(negedge clk);
      bus_wr = 1'b1; bus_rd = 1'b1; bus_wdata = 32'h9;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
      rd_word(w);
      check("R11 write wins, no advance", 64'(w), 64'h9);
      #1 check("R6 advance after read", 64'(bus_rdata[3:0]), 64'hA);
   endtask

   initial begin
      #1_000_000;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_preload();
      t_load();
      t_bounds();
      t_unpop();
      t_wrap();
      t_wdata_hi();
      t_reload_ignored();
      t_collide();
      repeat (2) @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule